// File: doc/BRIEF.md
# Bridge Interrupt Status Controller

This block carries interrupt traffic both ways across a bus bridge. In the outbound direction it catches events from the local side of the bridge: a level interrupt request, a write strobe from each mailbox register, and a pulse from each error detector. Each event sets its own sticky status bit. Each status bit has a matching enable bit. The active-low PCI interrupt output is pulled low while at least one status bit is both set and enabled.

In the inbound direction the block samples the PCI interrupt line arriving from the bus. It resynchronises the line into the local clock domain and detects its rising and falling transitions. Each transition type sets a sticky flag with its own enable, so the local interrupt output can follow rising transitions only, falling transitions only, or both.

Software services both directions through a small synchronous register port. Status registers are write-one-to-clear, enable registers are plain read/write, and reads return data combinationally from the presented address.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: While reset is held, and after it is released, all status and enable bits read zero, `pci_inta_n_o` is high and `local_irq_o` is low.
- R2: A clock edge at which `local_irq_i` is high sets outbound status bit 0 (register address 0).
- R3: A clock edge at which mailbox strobe `mbox_wr_i[k]` is high sets outbound status bit 1+k.
- R4: A clock edge at which error pulse `err_i[j]` is high sets outbound status bit 1+NUM_MBOX+j.
- R5: `pci_inta_n_o` is low exactly while some outbound status bit and the enable bit at the same position (register address 1) are both 1. It reflects a status or enable write from the edge that performs the write.
- R6: Writing a 1 to a bit of a status register (address 0 outbound, address 2 inbound) clears that bit, and writing a 0 leaves it unchanged. If a set event for that bit occurs at the same edge, the bit stays set.
- R7: Status bits stay set until they are cleared by a write. Writing 0 to an enable bit masks the interrupt output without clearing the status bit.
- R8: The incoming line passes through a two-flop synchronizer. A transition of `pci_int_line_i` made between edges sets its inbound flag at the third following clock edge.
- R9: Inbound status bit 0 flags a rising transition and bit 1 a falling transition (address 2). Enable bits 0 and 1 at address 3 select rising, falling or both. `local_irq_o` is high while any flag with its enable set is pending.
- R10: Addresses 4 to 7 read as zero and writes to them have no effect. Bits above bit 1 at addresses 2 and 3 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_irq_i | input | 1 | Local-side interrupt request, level |
| mbox_wr_i | input | NUM_MBOX | Per-mailbox write strobe |
| err_i | input | NUM_ERR | Per-error-source detection pulse |
| pci_int_line_i | input | 1 | Incoming PCI interrupt line, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | SRC_W | Register write data |
| reg_rdata_o | output | SRC_W | Register read data for `reg_addr_i` |
| pci_inta_n_o | output | 1 | Outbound PCI interrupt, active low |
| local_irq_o | output | 1 | Local interrupt request from inbound edges |

## Verification
Two things can land on the same status bit at the same edge: a software write-one-to-clear and a new event. On the outbound side the event is a local request, a mailbox strobe or an error pulse. On the inbound side it is a synchronized transition of the line. Directed steps line up a clear write with a held request and with a line transition timed to reach the edge detector at that edge. A long pseudo-random phase then lets such collisions happen freely. The behavioural model applies the rule that the event wins. It is compared against the interrupt outputs and the read data after every clock, so a bit that is wrongly cleared shows up in the following cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_OUT_STAT = 2'd0,
    SEL_OUT_EN   = 2'd1,
    SEL_IN_STAT  = 2'd2,
    SEL_IN_EN    = 2'd3
  } reg_sel_e;

  localparam int unsigned IN_W    = 2;
  localparam int unsigned IN_RISE = 0;
  localparam int unsigned IN_FALL = 1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_out_path.sv
module irq_out_path #(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] stat_o,
  output logic [SRC_W-1:0] en_o,
  output logic             pend_o
);
  logic [SRC_W-1:0] stat_q, stat_d;
  logic [SRC_W-1:0] en_q, en_d;
  logic             stat_ce;
  logic [SRC_W-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    stat_ce  = clr_we_i | (|set_i);
    stat_d   = (stat_q & ~clr_mask) | set_i;
    en_d     = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= en_d;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/irq_in_path.sv
module irq_in_path
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_i,
  input  logic            clr_we_i,
  input  logic            en_we_i,
  input  logic [IN_W-1:0] wdata_i,
  output logic [IN_W-1:0] stat_o,
  output logic [IN_W-1:0] en_o,
  output logic            pend_o
);
  logic            line_sync;
  logic            prev_q;
  logic [IN_W-1:0] edge_set;
  logic [IN_W-1:0] stat_q, stat_d;
  logic [IN_W-1:0] en_q, en_d;
  logic [IN_W-1:0] clr_mask;
  logic            stat_ce;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_sync;
  end

  always_comb begin
    edge_set          = '0;
    edge_set[IN_RISE] = line_sync & ~prev_q;
    edge_set[IN_FALL] = ~line_sync & prev_q;
    clr_mask          = clr_we_i ? wdata_i : '0;
    stat_ce           = clr_we_i | (|edge_set);
    stat_d            = (stat_q & ~clr_mask) | edge_set;
    en_d              = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= en_d;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_MBOX    = 4,
  parameter int unsigned NUM_ERR     = 3,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  localparam int unsigned SRC_W      = 1 + NUM_MBOX + NUM_ERR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                local_irq_i,
  input  logic [NUM_MBOX-1:0] mbox_wr_i,
  input  logic [NUM_ERR-1:0]  err_i,
  input  logic                pci_int_line_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [SRC_W-1:0]    reg_wdata_i,
  output logic [SRC_W-1:0]    reg_rdata_o,
  output logic                pci_inta_n_o,
  output logic                local_irq_o
);
  logic             rst_int_n;
  logic             addr_hit;
  reg_sel_e         sel;
  logic             out_clr_we, out_en_we, in_clr_we, in_en_we;
  logic [SRC_W-1:0] out_set;
  logic [SRC_W-1:0] out_stat, out_en;
  logic [IN_W-1:0]  in_stat, in_en;
  logic             out_pend, in_pend;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_int_n)
  );

  always_comb begin
    addr_hit   = (reg_addr_i[ADDR_W-1:2] == '0);
    sel        = reg_sel_e'(reg_addr_i[1:0]);
    out_clr_we = reg_wr_i && addr_hit && (sel == SEL_OUT_STAT);
    out_en_we  = reg_wr_i && addr_hit && (sel == SEL_OUT_EN);
    in_clr_we  = reg_wr_i && addr_hit && (sel == SEL_IN_STAT);
    in_en_we   = reg_wr_i && addr_hit && (sel == SEL_IN_EN);
    out_set    = {err_i, mbox_wr_i, local_irq_i};
  end

  irq_out_path #(.SRC_W(SRC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_i    (out_set),
    .clr_we_i (out_clr_we),
    .en_we_i  (out_en_we),
    .wdata_i  (reg_wdata_i),
    .stat_o   (out_stat),
    .en_o     (out_en),
    .pend_o   (out_pend)
  );

  irq_in_path #(.SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .line_i   (pci_int_line_i),
    .clr_we_i (in_clr_we),
    .en_we_i  (in_en_we),
    .wdata_i  (reg_wdata_i[IN_W-1:0]),
    .stat_o   (in_stat),
    .en_o     (in_en),
    .pend_o   (in_pend)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (addr_hit) begin
      case (sel)
        SEL_OUT_STAT: reg_rdata_o = out_stat;
        SEL_OUT_EN:   reg_rdata_o = out_en;
        SEL_IN_STAT:  reg_rdata_o = {{(SRC_W-IN_W){1'b0}}, in_stat};
        SEL_IN_EN:    reg_rdata_o = {{(SRC_W-IN_W){1'b0}}, in_en};
        default:      reg_rdata_o = '0;
      endcase
    end
  end

  assign pci_inta_n_o = ~out_pend;
  assign local_irq_o  = in_pend;
endmodule

// File: rtl/bridge_irq_ctrl_chk.sv
module bridge_irq_ctrl_chk #(
  parameter int unsigned NUM_MBOX = 4,
  parameter int unsigned NUM_ERR  = 3,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned SRC_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                local_irq_i,
  input logic [NUM_MBOX-1:0] mbox_wr_i,
  input logic [NUM_ERR-1:0]  err_i,
  input logic                reg_wr_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [SRC_W-1:0]    reg_wdata_i,
  input logic                pci_inta_n_o,
  input logic                local_irq_o,
  input logic [SRC_W-1:0]    out_stat,
  input logic [1:0]          in_stat,
  input logic [1:0]          in_en
);
  logic wr_out_stat, wr_out_en, wr_in_stat;
  assign wr_out_stat = reg_wr_i && (reg_addr_i == ADDR_W'(0));
  assign wr_out_en   = reg_wr_i && (reg_addr_i == ADDR_W'(1));
  assign wr_in_stat  = reg_wr_i && (reg_addr_i == ADDR_W'(2));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (pci_inta_n_o && !local_irq_o && out_stat == '0)
        else $error("outputs not idle during reset");
    end
  end

  assert_local_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    local_irq_i |=> out_stat[0]);

  assert_mbox_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mbox_wr_i) |=> (|out_stat[NUM_MBOX:1]));

  assert_err_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_i) |=> (|out_stat[SRC_W-1:NUM_MBOX+1]));

  assert_mask_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out_en && reg_wdata_i == '0) |=> pci_inta_n_o);

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out_stat && reg_wdata_i[0] && !local_irq_i) |=> !out_stat[0]);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out_stat && reg_wdata_i[0] && local_irq_i) |=> out_stat[0]);

  assert_sticky_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat[0] && !(wr_out_stat && reg_wdata_i[0])) |=> out_stat[0]);

  assert_sticky_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stat[0] && !(wr_in_stat && reg_wdata_i[0])) |=> in_stat[0]);

  assert_in_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en == 2'b00) |-> !local_irq_o);
endmodule

bind bridge_irq_ctrl bridge_irq_ctrl_chk #(
  .NUM_MBOX (NUM_MBOX),
  .NUM_ERR  (NUM_ERR),
  .ADDR_W   (ADDR_W),
  .SRC_W    (SRC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .local_irq_i  (local_irq_i),
  .mbox_wr_i    (mbox_wr_i),
  .err_i        (err_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .pci_inta_n_o (pci_inta_n_o),
  .local_irq_o  (local_irq_o),
  .out_stat     (out_stat),
  .in_stat      (in_stat),
  .in_en        (in_en)
);

// File: tb/sim_bridge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_bridge_irq_ctrl;
  localparam int NM = 4;
  localparam int NE = 3;
  localparam int AW = 3;
  localparam int SW = 1 + NM + NE;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          local_irq;
  logic [NM-1:0] mbox_wr;
  logic [NE-1:0] err;
  logic          line;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [SW-1:0] reg_wdata;
  logic [SW-1:0] reg_rdata;
  logic          inta_n;
  logic          lirq;

  always #5 clk = ~clk;

  bridge_irq_ctrl u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .local_irq_i    (local_irq),
    .mbox_wr_i      (mbox_wr),
    .err_i          (err),
    .pci_int_line_i (line),
    .reg_wr_i       (reg_wr),
    .reg_addr_i     (reg_addr),
    .reg_wdata_i    (reg_wdata),
    .reg_rdata_o    (reg_rdata),
    .pci_inta_n_o   (inta_n),
    .local_irq_o    (lirq)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string phase  = "R1";

  // behavioural reference state
  logic [SW-1:0] m_ostat, m_oen;
  logic [1:0]    m_istat, m_ien;
  logic          hist [3];

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] exp_rdata();
    case (reg_addr)
      3'd0: return m_ostat;
      3'd1: return m_oen;
      3'd2: return {{(SW-2){1'b0}}, m_istat};
      3'd3: return {{(SW-2){1'b0}}, m_ien};
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_ostat = '0; m_oen = '0; m_istat = '0; m_ien = '0;
    for (int i = 0; i < 3; i++) hist[i] = 1'b0;
  endtask

  task automatic model_step();
    logic [SW-1:0] clr;
    logic [1:0]    iclr, edges;
    clr  = (reg_wr && reg_addr == 3'd0) ? reg_wdata : '0;
    m_ostat = (m_ostat & ~clr) | {err, mbox_wr, local_irq};
    if (reg_wr && reg_addr == 3'd1) m_oen = reg_wdata;
    edges = {~hist[1] & hist[2], hist[1] & ~hist[2]};
    iclr  = (reg_wr && reg_addr == 3'd2) ? reg_wdata[1:0] : 2'b00;
    m_istat = (m_istat & ~iclr) | edges;
    if (reg_wr && reg_addr == 3'd3) m_ien = reg_wdata[1:0];
    hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = line;
  endtask

  task automatic compare();
    check(phase, "pci_inta_n", int'(inta_n), int'((m_ostat & m_oen) == '0));
    check(phase, "local_irq",  int'(lirq),   int'(|(m_istat & m_ien)));
    check(phase, "rdata",      int'(reg_rdata), int'(exp_rdata()));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [SW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [SW-1:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, "readback", int'(reg_rdata), int'(exp));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; local_irq = 0; mbox_wr = '0; err = '0; line = 0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check("R1", "inta_n in reset", int'(inta_n), 1);
    check("R1", "local_irq in reset", int'(lirq), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    for (int a = 0; a < 4; a++) rd(AW'(a), '0, "R1");

    // R2 + R5: status set while masked, then enable
    phase = "R2";
    local_irq = 1; tick(); local_irq = 0;
    rd(3'd0, SW'(1), "R2");
    check("R5", "masked inta_n", int'(inta_n), 1);
    phase = "R5";
    wr(3'd1, SW'(1));
    check("R5", "enabled inta_n", int'(inta_n), 0);

    // R3: each mailbox
    phase = "R3";
    wr(3'd0, '1);
    for (int k = 0; k < NM; k++) begin
      mbox_wr = NM'(1) << k; tick(); mbox_wr = '0;
      rd(3'd0, SW'(1) << (1 + k), "R3");
      wr(3'd0, SW'(1) << (1 + k));
    end

    // R4: each error source
    phase = "R4";
    for (int j = 0; j < NE; j++) begin
      err = NE'(1) << j; tick(); err = '0;
      rd(3'd0, SW'(1) << (1 + NM + j), "R4");
      wr(3'd0, SW'(1) << (1 + NM + j));
    end
    rd(3'd0, '0, "R6");

    // R5: enable only a mailbox bit, inta follows that bit only
    phase = "R5";
    wr(3'd1, SW'(1) << 2);
    local_irq = 1; tick(); local_irq = 0;
    check("R5", "unrelated pending bit", int'(inta_n), 1);
    mbox_wr = NM'(2); tick(); mbox_wr = '0;
    check("R5", "enabled mailbox bit", int'(inta_n), 0);

    // R6: clear colliding with new event; write 0 keeps bits
    phase = "R6";
    wr(3'd0, '0);
    rd(3'd0, SW'(5), "R6");
    local_irq = 1; wr(3'd0, SW'(1)); local_irq = 0;
    rd(3'd0, SW'(5), "R6");
    wr(3'd0, SW'(4));
    rd(3'd0, SW'(1), "R6");

    // R7: masking keeps status
    phase = "R7";
    wr(3'd1, SW'(1));
    check("R7", "enabled", int'(inta_n), 0);
    wr(3'd1, '0);
    check("R7", "masked", int'(inta_n), 1);
    repeat (3) tick();
    rd(3'd0, SW'(1), "R7");
    wr(3'd0, '1);

    // R8: exact latency through synchronizer
    phase = "R8";
    wr(3'd3, SW'(1));
    line = 1;
    tick(); tick();
    check("R8", "rise flag not yet", int'(lirq), 0);
    tick();
    check("R8", "rise flag after third edge", int'(lirq), 1);
    rd(3'd2, SW'(1), "R8");

    // R9: falling only, both
    phase = "R9";
    wr(3'd2, SW'(3));
    wr(3'd3, SW'(2));
    line = 0; repeat (3) tick();
    check("R9", "fall enabled", int'(lirq), 1);
    rd(3'd2, SW'(2), "R9");
    wr(3'd2, SW'(2));
    line = 1; repeat (3) tick();
    check("R9", "rise masked", int'(lirq), 0);
    rd(3'd2, SW'(1), "R9");
    wr(3'd2, SW'(1));
    wr(3'd3, SW'(3));
    line = 0; repeat (3) tick();
    check("R9", "both enabled fall", int'(lirq), 1);
    // R6 inbound: clear at the edge where a new rise lands
    phase = "R6";
    line = 1; tick(); tick();
    wr(3'd2, SW'(3));
    rd(3'd2, SW'(1), "R6");
    wr(3'd2, SW'(3));

    // R10: unmapped addresses and unused bits
    phase = "R10";
    for (int a = 4; a < 8; a++) begin
      wr(AW'(a), '1);
      rd(AW'(a), '0, "R10");
    end
    rd(3'd1, '0, "R10");
    wr(3'd3, '1);
    rd(3'd3, SW'(3), "R10");

    // mixed traffic, collisions checked against the model every cycle
    phase = "R6 mixed";
    lfsr = 32'hACE1_1234;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      local_irq = lfsr[3] & lfsr[9];
      mbox_wr   = lfsr[7:4] & lfsr[15:12];
      err       = lfsr[18:16] & lfsr[22:20] & lfsr[26:24];
      if (lfsr[27] & lfsr[28] & lfsr[29]) line = ~line;
      reg_wr    = lfsr[30];
      reg_addr  = lfsr[2:0];
      reg_wdata = lfsr[SW+10:11];
      tick();
    end
    reg_wr = 0; local_irq = 0; mbox_wr = '0; err = '0;
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule